// File: doc/BRIEF.md
# Dual-Edge Input Capture Channel Pair

This block times the interval between two chosen edges on a single asynchronous input pin. The pin passes through a two-stage synchronizer, and a rising or falling edge is detected from it. A free-running counter supplied from outside is copied into a first capture register when the first chosen edge arrives. It is copied into a second capture register when the second chosen edge arrives on the same pin. Each of the two channels has its own edge-select field, flag and interrupt enable.

Measurements are one-shot. Software clears both flags and then sets an arm bit. Hardware clears the arm bit in the same clock that it stores the second value, so a cleared arm bit or a set second flag means both values are ready. Reading the first capture register copies the second register into a shadow. A later read of the second register returns that shadow, so the two values read always belong to the same measurement, provided the first register is read first.

The register port has no handshake. Writes take effect on the clock edge at which `wr_en` is high. `rdata` is a combinational decode of `addr`. A read counts for the shadow copy on the edge at which `rd_en` is high.

Top module: `edge_pair_capture`

## Requirements
- R1: With the first edge select (CFG bits 1:0) set to 01 (rising) or 10 (falling), the first matching edge seen while armed loads the counter into CAP_A (address 3). Bit 0 of the flag register (address 2) is set at the same time.
- R2: After CAP_A is loaded, the second edge select (CFG bits 3:2, same coding) is matched on the same pin, starting from the next clock. A match loads the counter into CAP_B (address 4) and sets flag bit 1. An edge that triggered the first capture never triggers the second.
- R3: Capture occurs only when control bit 0 (global enable) is 1, control bit 1 (pair enable) is 1 and control bit 2 (mode) is 0. Control is at address 0.
- R4: Control bit 3 (arm) gates capture. Hardware clears it when CAP_B is loaded, which limits each arming to exactly one pair. While it is clear, edges change neither capture register nor any flag.
- R5: The flag bits are cleared by writing 1 to them at address 2. Writing 0 to a flag bit leaves it unchanged.
- R6: `irq_a_o` is high exactly when flag 0 and enable CFG bit 4 are both 1. `irq_b_o` is high exactly when flag 1 and enable CFG bit 5 are both 1.
- R7: A read of CAP_A copies CAP_B into a shadow. Reads of CAP_B return the shadow, even if a newer pair has been captured since then.
- R8: An edge-select code of 00 or 11 disables capture for that channel.
- R9: After reset, every readable register reads zero and both interrupt outputs are low.
- R10: A stored value equals the counter input as sampled at the third rising clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Free-running counter value |
| pin_i | input | 1 | Asynchronous measured input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for the shadow copy) |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr` |
| irq_a_o | output | 1 | First channel interrupt |
| irq_b_o | output | 1 | Second channel interrupt |

## Verification
A wrong phase state shows up within a few clocks as a CAP_B value taken on the first edge, or as an arm bit that stays set after the pulse. A stale or missing shadow shows up on the very next CAP_B read as a value from a different measurement. The bench drives a known counter, so every stored value can be checked to the exact cycle. An off-by-one in the synchronizer or edge detector therefore shows as a difference of one count.

// File: rtl/edge_pair_capture.sv
module edge_pair_capture #(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_i,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq_a_o,
  output logic             irq_b_o
);
  localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_FLAG = 3'd2,
                         A_CAPA = 3'd3, A_CAPB = 3'd4;

  logic [SYNC_STAGES:0] sync;
  logic glb_en, pair_en, mode, arm, got_first;
  logic [1:0] sel_a, sel_b;
  logic ie_a, ie_b, flag_a, flag_b;
  logic [CNT_W-1:0] cap_a, cap_b, shadow_b;

  wire rise = sync[SYNC_STAGES-1] & ~sync[SYNC_STAGES];
  wire fall = ~sync[SYNC_STAGES-1] & sync[SYNC_STAGES];
  wire mode_on = glb_en & pair_en & ~mode;
  wire wr_ctrl = wr_en && addr == A_CTRL;

  function automatic logic match(input logic [1:0] sel, input logic r, input logic f);
    return (sel == 2'b01) ? r : (sel == 2'b10) ? f : 1'b0;
  endfunction

  wire hit_a = mode_on & arm & ~got_first & match(sel_a, rise, fall);
  wire hit_b = mode_on & arm & got_first & match(sel_b, rise, fall);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[SYNC_STAGES-1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {glb_en, pair_en, mode, arm, got_first} <= '0;
      {sel_a, sel_b, ie_a, ie_b} <= '0;
    end else begin
      if (wr_ctrl) {mode, pair_en, glb_en} <= wdata[2:0];
      if (hit_b)        arm <= 1'b0;
      else if (wr_ctrl) arm <= wdata[3];
      if (hit_b || wr_ctrl) got_first <= 1'b0;
      else if (hit_a)       got_first <= 1'b1;
      if (wr_en && addr == A_CFG) {ie_b, ie_a, sel_b, sel_a} <= wdata[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {flag_a, flag_b} <= '0;
      cap_a <= '0;
      cap_b <= '0;
      shadow_b <= '0;
    end else begin
      flag_a <= hit_a | (flag_a & ~(wr_en && addr == A_FLAG && wdata[0]));
      flag_b <= hit_b | (flag_b & ~(wr_en && addr == A_FLAG && wdata[1]));
      if (hit_a) cap_a <= cnt_i;
      if (hit_b) cap_b <= cnt_i;
      if (rd_en && addr == A_CAPA) shadow_b <= cap_b;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata[3:0] = {arm, mode, pair_en, glb_en};
      A_CFG:  rdata[5:0] = {ie_b, ie_a, sel_b, sel_a};
      A_FLAG: rdata[1:0] = {flag_b, flag_a};
      A_CAPA: rdata = cap_a;
      A_CAPB: rdata = shadow_b;
      default: rdata = '0;
    endcase
  end

  assign irq_a_o = flag_a & ie_a;
  assign irq_b_o = flag_b & ie_b;

  a_r2_b_after_a: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_b != $past(cap_b)) |-> $past(got_first && arm));
  a_r4_arm_drops_with_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b) |-> !arm);
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(cap_a) && $stable(cap_b));
  a_r3_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |=> $stable(cap_a) && $stable(cap_b));
  a_r1_flag_with_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> got_first);
endmodule

// File: tb/test_edge_pair_capture.sv
`timescale 1ns/1ps
module test_edge_pair_capture;
  logic clk = 0, rst_n = 0, pin = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, cnt = 0, rdata;
  logic irq_a, irq_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  edge_pair_capture i_edge_pair_capture (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_i(pin), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_a_o(irq_a), .irq_b_o(irq_b));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic drive(input logic v, output logic [15:0] c);
    @(negedge clk); pin = v; c = cnt;
    repeat (4) @(negedge clk);
  endtask

  task automatic arm_for(input logic [15:0] cfg);
    wr(2, 16'h3);
    wr(1, cfg);
    wr(0, 16'hB);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d);
      check("R9 register zero", d, 0);
    end
    check("R9 irq low", {irq_a, irq_b}, 0);
  endtask

  task automatic t_basic;
    logic [15:0] c1, c2, d, x;
    arm_for(16'h9);
    drive(1, c1); drive(0, c2);
    rd(3, d); check("R1 R10 CAP_A rising", d, c1 + 16'd2);
    rd(4, d); check("R2 CAP_B falling", d, c2 + 16'd2);
    rd(0, d); check("R4 arm self-cleared", d, 16'h3);
    rd(2, d); check("R1 R2 flags", d, 16'h3);
    drive(1, x); drive(0, x);
    rd(3, d); check("R4 one pair per arming", d, c1 + 16'd2);
    rd(2, d); check("R4 flags untouched while idle", d, 16'h3);
  endtask

  task automatic t_w1c;
    logic [15:0] d;
    wr(2, 16'h1); rd(2, d); check("R5 clear flag A only", d, 16'h2);
    wr(2, 16'h0); rd(2, d); check("R5 zero write keeps", d, 16'h2);
    wr(2, 16'h2); rd(2, d); check("R5 clear flag B", d, 16'h0);
  endtask

  task automatic t_irq;
    logic [15:0] c;
    arm_for(16'h39);
    check("R6 irq idle", {irq_a, irq_b}, 0);
    drive(1, c); check("R6 irq A only", {irq_a, irq_b}, 16'h2);
    drive(0, c); check("R6 both irq", {irq_a, irq_b}, 16'h3);
    wr(1, 16'h29); check("R6 enable A off", {irq_a, irq_b}, 16'h1);
    wr(2, 16'h3); check("R6 irq cleared", {irq_a, irq_b}, 0);
  endtask

  task automatic t_reverse;
    logic [15:0] c1, c2, d, x;
    wr(0, 0); drive(1, x);
    arm_for(16'h6);
    drive(0, c1); drive(1, c2);
    rd(3, d); check("R1 CAP_A falling", d, c1 + 16'd2);
    rd(4, d); check("R2 CAP_B rising", d, c2 + 16'd2);
    wr(0, 0); drive(0, x);
  endtask

  task automatic t_same_edge;
    logic [15:0] c1, c2, d, x;
    arm_for(16'h5);
    drive(1, c1); drive(0, x);
    rd(0, d); check("R2 still armed after one rise", d, 16'hB);
    drive(1, c2); drive(0, x);
    rd(3, d); check("R2 CAP_A first rise", d, c1 + 16'd2);
    rd(4, d); check("R2 CAP_B next rise", d, c2 + 16'd2);
  endtask

  task automatic t_gating;
    logic [15:0] d, x, old;
    rd(3, old);
    wr(2, 3); wr(1, 16'h9); wr(0, 16'hF);
    drive(1, x); drive(0, x);
    rd(2, d); check("R3 mode bit blocks", d, 0);
    rd(3, d); check("R3 CAP_A kept", d, old);
    wr(0, 16'h9);
    drive(1, x); drive(0, x);
    rd(2, d); check("R3 pair enable blocks", d, 0);
    wr(0, 16'hA);
    drive(1, x); drive(0, x);
    rd(2, d); check("R3 global enable blocks", d, 0);
    wr(0, 0);
  endtask

  task automatic t_disabled_codes;
    logic [15:0] d, x;
    arm_for(16'h8);
    drive(1, x); drive(0, x);
    rd(2, d); check("R8 code 00 disables A", d, 0);
    arm_for(16'hD);
    drive(1, x); drive(0, x); drive(1, x); drive(0, x);
    rd(2, d); check("R8 code 11 disables B", d, 16'h1);
    rd(0, d); check("R8 arm stays set", d, 16'hB);
    wr(0, 0);
  endtask

  task automatic t_coherent;
    logic [15:0] a0, a1, b0, b1, d;
    arm_for(16'h9);
    drive(1, a0); repeat (3) @(negedge clk); drive(0, a1);
    rd(3, d); check("R7 first pair A", d, a0 + 16'd2);
    arm_for(16'h9);
    repeat (7) @(negedge clk);
    drive(1, b0); drive(0, b1);
    rd(4, d); check("R7 shadow keeps old B", d, a1 + 16'd2);
    rd(3, d); check("R7 new A", d, b0 + 16'd2);
    rd(4, d); check("R7 new B after A read", d, b1 + 16'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_w1c;
    t_irq;
    t_reverse;
    t_same_edge;
    t_gating;
    t_disabled_codes;
    t_coherent;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule